// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After a hardware reset this block fetches the station address and a set of configuration words from an external three-wire serial EEPROM, with no action from software. It borrows three lines of the local memory data bus for the transfer: one line carries the serial clock, one carries the command and address stream into the EEPROM, and one returns the EEPROM's data. Each 16-bit word it reads is split into two bytes and stored in an internal byte register file.

The first three words hold the six-byte node address. A parameter sets how many configuration words follow. After the last word the block raises a done flag and stops driving the borrowed lines, so the memory controller can take the bus back. Other logic reads the loaded bytes through a simple index/data read port.

Top module: `cfg_rom_loader`

## Requirements
- R1: While reset is held and right after it is released, the chip select is high, bus bits 1 and 2 are driven (enable pattern 3'b110), bit 0 is never driven, the done flag is low and every register byte reads 0.
- R2: The serial clock (bus bit 2) has a period of 2*HALF_CYCLES system clocks (30 at 50 MHz gives 1.2 us).
- R3: Each word read shifts out on bus bit 1, MSB first: a start bit 1, the read opcode 10, then an ADDR_W-bit address. Word k uses address k.
- R4: The command line changes only when the serial clock falls or when the chip select rises. The returned line is sampled on rising serial-clock edges.
- R5: After the address, one dummy bit is skipped and the next 16 rising edges capture the data word MSB first.
- R6: Between two word reads the chip select stays low for at least one full serial-clock period, and the serial clock stays low whenever chip select is low.
- R7: Word k is stored with its high byte at index 2k and its low byte at index 2k+1, so the node address sits in bytes 0 to 5. Any index at or above 2*(3+CFG_WORDS) reads 0.
- R8: Exactly 3+CFG_WORDS words are read per load.
- R9: When the load ends, the done flag rises and stays high until the next reset. The chip select and serial clock are low, and all bus output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low hardware reset; each release starts a load |
| romDataIn | input | 1 | Bus bit 0 during the load: data returned by the EEPROM |
| busOut | output | 3 | Values for bus bits 2..0: {serial clock, command data, 0} |
| busOe | output | 3 | Output enables for bus bits 2..0 |
| romSel | output | 1 | EEPROM chip select, active high |
| loadDone | output | 1 | High once the load has finished and the bus lines are released |
| rdIdx | input | $clog2(2*(3+CFG_WORDS)+1) | Byte index of the read port |
| rdByte | output | 8 | Register byte selected by rdIdx |

## Verification
The bench builds the loader with HALF_CYCLES = 3 and CFG_WORDS = 3. The short serial period keeps each full load to about a thousand system clocks. Six words make the node-address block and several configuration words pass through the same path, and they leave a 4-bit read index wide enough to address bytes past the end of the file. A behavioural EEPROM model decodes each command, checks the address sequence, serves a computed word and queues the expected bytes. After done, a monitor reads every byte back and compares it with the queue.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

  // number of 16-bit words that make up the node address
  localparam int ID_WORDS = 3;
  localparam int WORD_W   = 16;

  typedef enum logic [1:0] {
    ST_READ = 2'd0,
    ST_GAP  = 2'd1,
    ST_DONE = 2'd2
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;  // capture one returned bit
    logic commit;   // write the assembled word into the register file
  } dpStrobe_t;

endpackage

// File: rtl/cfgld_ctrl.sv
`timescale 1ns/1ps
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int HALF_CYCLES = 30,
  parameter int NUM_WORDS   = 5,
  parameter int ADDR_W      = 6
) (
  input  logic      clk,
  input  logic      rstN,
  output dpStrobe_t strb,
  output logic      sclk,
  output logic      di,
  output logic      cs,
  output logic      done
);

  localparam int HC_W     = $clog2(HALF_CYCLES) + 1;
  localparam int WD_W     = $clog2(NUM_WORDS) + 1;
  localparam int CMD_LEN  = 3 + ADDR_W;
  localparam int DUMMY_IX = CMD_LEN;
  localparam int LAST_IX  = CMD_LEN + WORD_W;
  localparam int CI_W     = $clog2(LAST_IX + 1);

  ldState_t        state;
  logic [HC_W-1:0] halfCnt;
  logic            halfTick;
  logic            phase;
  logic            gapHalf;
  logic [CI_W-1:0] cycIdx;
  logic [WD_W-1:0] wordIdx;
  logic [CMD_LEN-1:0] cmdWord;
  logic [CMD_LEN-1:0] cmdShift;

  assign halfTick = (state != ST_DONE) && (halfCnt == HC_W'(HALF_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (state == ST_DONE || halfTick) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_READ;
      phase   <= 1'b0;
      gapHalf <= 1'b0;
      cycIdx  <= '0;
      wordIdx <= '0;
    end else if (halfTick) begin
      case (state)
        ST_READ: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (cycIdx == CI_W'(LAST_IX)) begin
              state   <= ST_GAP;
              gapHalf <= 1'b0;
            end else begin
              cycIdx <= cycIdx + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (!gapHalf) begin
            gapHalf <= 1'b1;
          end else if (wordIdx == WD_W'(NUM_WORDS - 1)) begin
            state <= ST_DONE;
          end else begin
            wordIdx <= wordIdx + 1'b1;
            cycIdx  <= '0;
            state   <= ST_READ;
          end
        end
        default: ;
      endcase
    end
  end

  // start bit, read opcode, word address
  assign cmdWord  = {1'b1, 2'b10, ADDR_W'(wordIdx)};
  assign cmdShift = cmdWord << cycIdx;

  assign di   = (state == ST_READ) && (cycIdx < CI_W'(CMD_LEN)) && cmdShift[CMD_LEN-1];
  assign sclk = phase;
  assign cs   = (state == ST_READ);
  assign done = (state == ST_DONE);

  assign strb.shiftIn = halfTick && (state == ST_READ) && !phase
                        && (cycIdx > CI_W'(DUMMY_IX));
  assign strb.commit  = halfTick && (state == ST_READ) && phase
                        && (cycIdx == CI_W'(LAST_IX));

  // R4
  di_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(di) |-> ($fell(sclk) || $rose(cs)));

  // R6
  gap_clock_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> !sclk);

  // R6
  gap_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cs) |=> !cs);

  // R2
  sclk_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> $past(halfTick));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

endmodule

// File: rtl/cfgld_dp.sv
`timescale 1ns/1ps
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             sdIn,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdByte
);

  localparam int NBYTES = 2 * NUM_WORDS;
  localparam int WD_W   = $clog2(NUM_WORDS) + 1;

  logic [WORD_W-1:0] shiftReg;
  logic [WD_W-1:0]   wrPtr;
  logic [7:0]        regFile [NBYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wrPtr    <= '0;
    end else begin
      if (strb.shiftIn) shiftReg <= {shiftReg[WORD_W-2:0], sdIn};
      if (strb.commit)  wrPtr    <= wrPtr + 1'b1;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[2*w]   <= '0;
        regFile[2*w+1] <= '0;
      end else if (strb.commit && wrPtr == WD_W'(w)) begin
        regFile[2*w]   <= shiftReg[15:8];
        regFile[2*w+1] <= shiftReg[7:0];
      end
    end
  end

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rdIdx == IDX_W'(i)) rdByte = regFile[i];
    end
  end

  // R8
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (wrPtr < WD_W'(NUM_WORDS)));

  // R5
  no_shift_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit && strb.shiftIn));

endmodule

// File: rtl/cfg_rom_loader.sv
`timescale 1ns/1ps
module cfg_rom_loader
  import cfgld_pkg::*;
#(
  parameter int HALF_CYCLES = 30,
  parameter int CFG_WORDS   = 2,
  parameter int ADDR_W      = 6,
  localparam int NUM_WORDS  = ID_WORDS + CFG_WORDS,
  localparam int IDX_W      = $clog2(2 * NUM_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             romDataIn,
  output logic [2:0]       busOut,
  output logic [2:0]       busOe,
  output logic             romSel,
  output logic             loadDone,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdByte
);

  dpStrobe_t strb;
  logic      sclk;
  logic      di;

  cfgld_ctrl #(
    .HALF_CYCLES(HALF_CYCLES),
    .NUM_WORDS  (NUM_WORDS),
    .ADDR_W     (ADDR_W)
  ) i_ctrl (
    .clk (clk),
    .rstN(rstN),
    .strb(strb),
    .sclk(sclk),
    .di  (di),
    .cs  (romSel),
    .done(loadDone)
  );

  cfgld_dp #(
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .sdIn  (romDataIn),
    .rdIdx (rdIdx),
    .rdByte(rdByte)
  );

  assign busOut = {sclk, di, 1'b0};
  assign busOe  = {!loadDone, !loadDone, 1'b0};

endmodule

// File: tb/test_cfg_rom_loader.sv
`timescale 1ns/1ps
module test_cfg_rom_loader;

  localparam int TB_HALF = 3;
  localparam int TB_CFG  = 3;
  localparam int NW      = 3 + TB_CFG;
  localparam int NB      = 2 * NW;
  localparam int IW      = $clog2(NB + 1);
  localparam int PERIOD_NS = 2 * TB_HALF * 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic          romDataIn;
  logic [2:0]    busOut;
  logic [2:0]    busOe;
  logic          romSel;
  logic          loadDone;
  logic [IW-1:0] rdIdx;
  logic [7:0]    rdByte;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_rom_loader #(.HALF_CYCLES(TB_HALF), .CFG_WORDS(TB_CFG)) i_cfg_rom_loader (
    .clk(clk), .rstN(rstN), .romDataIn(romDataIn), .busOut(busOut), .busOe(busOe),
    .romSel(romSel), .loadDone(loadDone), .rdIdx(rdIdx), .rdByte(rdByte)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] romWord(input int a);
    logic [7:0] b;
    b = 8'(a);
    return 16'h9E37 ^ {b * 8'd37 + 8'd5, b * 8'd91 + 8'd13};
  endfunction

  // scoreboard queue, filled by the EEPROM-side driver
  logic [7:0] expQ[$];

  task automatic pushWord(input logic [15:0] w);
    expQ.push_back(w[15:8]);
    expQ.push_back(w[7:0]);
  endtask

  // behavioural EEPROM
  int         riseCnt = 0;
  int         served  = 0;
  logic [8:0] cmdSh   = '0;
  logic [15:0] curWord = '0;
  time        lastRise = 0;
  int         periodViol = 0;

  always @(posedge romSel) begin
    riseCnt = 0;
    cmdSh   = '0;
  end

  always @(posedge busOut[2]) begin
    if (romSel) begin
      riseCnt++;
      if (riseCnt > 1 && ($time - lastRise) != PERIOD_NS) periodViol++;
      lastRise = $time;
      if (riseCnt <= 9) cmdSh = {cmdSh[7:0], busOut[1]};
      if (riseCnt == 9) begin
        // R3: start 1, opcode 10, address = word number
        check(cmdSh == {1'b1, 2'b10, 6'(served)}, "R3 command", int'(cmdSh),
              int'({1'b1, 2'b10, 6'(served)}));
        curWord = romWord(served);
        pushWord(curWord);
        served++;
      end
    end
  end

  always @(negedge busOut[2]) begin
    if (romSel) begin
      if (riseCnt == 9) romDataIn = 1'b1 ^ 1'b1;        // dummy 0
      else if (riseCnt >= 10 && riseCnt <= 25) romDataIn = curWord[25 - riseCnt];
      else romDataIn = 1'b0;
    end
  end

  // line-level watchers sampled away from the active edge
  logic prevSclk = 1'b0, prevDi = 1'b0, prevSel = 1'b0;
  int   diViol = 0, lowSelClk = 0, gapLen = 0, minGap = 1000000, gaps = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (romSel && busOut[2] && prevSclk && busOut[1] != prevDi) diViol++;
      if (!romSel && busOut[2]) lowSelClk++;
      if (!romSel) gapLen++;
      if (romSel && !prevSel) begin
        gaps++;
        if (gapLen < minGap) minGap = gapLen;
        gapLen = 0;
      end
    end
    prevSclk = busOut[2];
    prevDi   = busOut[1];
    prevSel  = romSel;
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (load never completed)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    rstN = 1'b0;
    rdIdx = '0;
    romDataIn = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(romSel == 1'b1, "R1 select in reset", romSel, 1);
    check(busOe == 3'b110, "R1 enables in reset", busOe, 3'b110);
    check(busOut == 3'b010, "R3 start bit in reset", busOut, 3'b010);
    check(loadDone == 1'b0, "R1 done low", loadDone, 0);
    check(rdByte == 8'h00, "R1 registers zero", rdByte, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busOe == 3'b110 && romSel, "R1 driving after release", busOe, 3'b110);

    while (!loadDone) @(negedge clk);

    // R9 release state
    check(busOe == 3'b000, "R9 enables released", busOe, 0);
    check(romSel == 1'b0, "R9 select low", romSel, 0);
    check(busOut[2] == 1'b0, "R9 clock low", busOut[2], 0);
    // R8 word count
    check(served == NW, "R8 words read", served, NW);
    check(expQ.size() == NB, "R8 queued bytes", expQ.size(), NB);

    // monitor: read back and compare in order (R5 data, R7 placement)
    for (int i = 0; i < NB; i++) begin
      rdIdx = IW'(i);
      @(negedge clk);
      exp = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
      check(rdByte === exp, (i < 6) ? "R7 node byte" : "R5 config byte", rdByte, exp);
    end
    rdIdx = IW'(NB);
    @(negedge clk);
    check(rdByte == 8'h00, "R7 out of range", rdByte, 0);
    rdIdx = '1;
    @(negedge clk);
    check(rdByte == 8'h00, "R7 top index", rdByte, 0);

    repeat (50) @(negedge clk);
    check(loadDone == 1'b1, "R9 done holds", loadDone, 1);
    check(romSel == 1'b0 && busOe == 3'b000, "R9 still released", busOe, 0);

    check(periodViol == 0, "R2 serial period", periodViol, 0);
    check(diViol == 0, "R4 command changes on fall only", diViol, 0);
    check(lowSelClk == 0, "R6 clock low while deselected", lowSelClk, 0);
    check(gaps == NW - 1, "R6 gap count", gaps, NW - 1);
    check(minGap >= 2 * TB_HALF, "R6 gap length", minGap, 2 * TB_HALF);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule